// File: doc/BRIEF.md
# Fixed-Page Hardware Stack Controller

This block keeps an 8-bit stack pointer and turns stack commands into byte accesses on a single-port memory. The stack lives in one fixed 256-byte page, with the upper address byte set to 0x01. Each command is taken over a valid/ready handshake, and the block runs the memory accesses that command needs, one per cycle. The commands are single-byte push, pop and peek, a status push that forces two flag bits on, a call that saves a 16-bit return address, a return that restores it, and a direct load of the pointer.

Pushes write at the pointer and then move it down. Pops move the pointer up and then read at the new place. The pointer wraps modulo 256 and raises no error. Read data and the rebuilt program counter come back on a response port with a one-cycle valid pulse. The memory array, vector fetch and instruction decode sit outside the block.

Top module: `hwstack_top`

## Requirements
- R1: Every memory access goes to address {0x01, byte}. A write uses the current pointer as the low byte. A read (pop, peek, return) uses pointer+1. The memory returns read data one cycle after the cycle in which it sees `memRdEn`.
- R2: Push (cmdOp=0) writes `cmdData` at the current pointer and then decrements the pointer. Two pushes from 0xFF write the first byte at 0x1FF and the second at 0x1FE, and leave the pointer at 0xFD.
- R3: Pop (cmdOp=1) first increments the pointer and then reads at the new pointer. The byte comes back on `rspData` with `rspValid` high for exactly one cycle.
- R4: Peek (cmdOp=2) reads at pointer+1, returns the byte like a pop, and leaves the pointer unchanged.
- R5: Call (cmdOp=3) computes cmdPc-1. It pushes the high byte of that value first and the low byte second, so the pointer drops by two.
- R6: Return (cmdOp=4) pops the low byte first and the high byte second. It drives {high, low}+1 on `rspPc` and the high byte on `rspData`, and the pointer rises by two.
- R7: Status push (cmdOp=5) writes `cmdData` with bits 4 and 5 forced to 1 (OR 0x30), using push ordering.
- R8: The pointer wraps modulo 256. A push at 0x00 writes 0x100 and leaves 0xFF. A pop at 0xFF reads 0x100 and leaves 0x00.
- R9: Reset sets the pointer to 0xFF. Load (cmdOp=6) sets the pointer to `cmdData` at the accepting edge, with no memory access.
- R10: `cmdReady` is high only when no command is in progress. A command is accepted when `cmdValid` and `cmdReady` are both high. After a command that touches memory is accepted, `cmdReady` is low in the next cycle. Code 7 is accepted and has no effect: no access and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block idle and able to take a command |
| cmdOp | input | 3 | Command code (see requirements) |
| cmdData | input | 8 | Byte to push, status byte, or new pointer value |
| cmdPc | input | 16 | Program counter for a call |
| memAddr | output | 16 | Memory address |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 8 | Memory write byte |
| memRdEn | output | 1 | Memory read strobe |
| memRdData | input | 8 | Read byte, valid one cycle after memRdEn |
| rspValid | output | 1 | One-cycle pulse when a read result is ready |
| rspData | output | 8 | Byte read by pop, peek or return |
| rspPc | output | 16 | Restored program counter after a return |
| stackPtr | output | 8 | Current stack pointer |

## Verification
The assertions assume that `memRdData` shows the addressed byte exactly one cycle after a read strobe, and that `cmdOp` and `cmdValid` are stable over the accepting edge. The bench holds to both. Its memory model registers read data on the strobe edge, and it changes command inputs only on falling edges, holding them for one full cycle. It never relies on a response before the block is idle again. The pointer-motion assertions tie each write or read address to the pointer value one cycle later. They do not depend on what the memory holds.

// File: rtl/hwstack_pkg.sv
package hwstack_pkg;

  typedef enum logic [2:0] {
    OP_PUSH        = 3'd0,
    OP_POP         = 3'd1,
    OP_PEEK        = 3'd2,
    OP_CALL        = 3'd3,
    OP_RET         = 3'd4,
    OP_PUSH_STATUS = 3'd5,
    OP_LOAD_PTR    = 3'd6,
    OP_NONE        = 3'd7
  } stackOp_e;

  // strobes from control to datapath, one per cycle
  typedef struct packed {
    logic latch;        // capture write operands
    logic latchCall;    // operands come from cmdPc-1
    logic latchStatus;  // force status bits on byte0
    logic loadPtr;      // pointer <= cmdData
    logic wrByte0;      // write first byte, decrement
    logic wrByte1;      // write second byte, decrement
    logic rdIssue;      // read at pointer+1
    logic rdPeek;       // keep pointer on this read
    logic capLo;        // hold first byte of a return
    logic finish;       // capture response
    logic finishRet;    // response carries a program counter
  } stackStrobe_t;

endpackage

// File: rtl/hwstack_ctrl.sv
module hwstack_ctrl
  import hwstack_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic [2:0]   cmdOp,
  output logic         cmdReady,
  output stackStrobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE0, ST_WRITE1, ST_READ0, ST_READ1, ST_FINISH
  } ctrlState_e;

  ctrlState_e state, nxtState;
  logic       isCall, isPeek, isRet;
  stackOp_e   op;
  logic       accept;

  assign op       = stackOp_e'(cmdOp);
  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdValid && cmdReady;

  always_comb begin
    stb      = '0;
    nxtState = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          unique case (op)
            OP_PUSH: begin
              stb.latch = 1'b1;
              nxtState  = ST_WRITE0;
            end
            OP_PUSH_STATUS: begin
              stb.latch       = 1'b1;
              stb.latchStatus = 1'b1;
              nxtState        = ST_WRITE0;
            end
            OP_CALL: begin
              stb.latch     = 1'b1;
              stb.latchCall = 1'b1;
              nxtState      = ST_WRITE0;
            end
            OP_POP, OP_PEEK, OP_RET: nxtState = ST_READ0;
            OP_LOAD_PTR: stb.loadPtr = 1'b1;
            default: ;
          endcase
        end
      end
      ST_WRITE0: begin
        stb.wrByte0 = 1'b1;
        nxtState    = isCall ? ST_WRITE1 : ST_IDLE;
      end
      ST_WRITE1: begin
        stb.wrByte1 = 1'b1;
        nxtState    = ST_IDLE;
      end
      ST_READ0: begin
        stb.rdIssue = 1'b1;
        stb.rdPeek  = isPeek;
        nxtState    = isRet ? ST_READ1 : ST_FINISH;
      end
      ST_READ1: begin
        stb.rdIssue = 1'b1;
        stb.capLo   = 1'b1;
        nxtState    = ST_FINISH;
      end
      ST_FINISH: begin
        stb.finish    = 1'b1;
        stb.finishRet = isRet;
        nxtState      = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isCall <= 1'b0;
      isPeek <= 1'b0;
      isRet  <= 1'b0;
    end else begin
      state <= nxtState;
      if (accept) begin
        isCall <= (op == OP_CALL);
        isPeek <= (op == OP_PEEK);
        isRet  <= (op == OP_RET);
      end
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    accept && (cmdOp != 3'd6) && (cmdOp != 3'd7) |=> !cmdReady); // R10

  AST_NONE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    accept && ((cmdOp == 3'd6) || (cmdOp == 3'd7)) |=> cmdReady); // R10

endmodule

// File: rtl/hwstack_dp.sv
module hwstack_dp
  import hwstack_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter int                PAGE_W       = 8,
  parameter logic [PAGE_W-1:0] PAGE_ID      = 8'h01,
  parameter logic [DATA_W-1:0] SP_INIT      = 8'hFF,
  parameter logic [DATA_W-1:0] STATUS_FORCE = 8'h30
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stackStrobe_t             stb,
  input  logic [DATA_W-1:0]        cmdData,
  input  logic [2*DATA_W-1:0]      cmdPc,
  output logic [PAGE_W+DATA_W-1:0] memAddr,
  output logic                     memWrEn,
  output logic [DATA_W-1:0]        memWrData,
  output logic                     memRdEn,
  input  logic [DATA_W-1:0]        memRdData,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData,
  output logic [2*DATA_W-1:0]      rspPc,
  output logic [DATA_W-1:0]        stackPtr
);

  localparam int PTR_W = DATA_W;
  localparam int PC_W  = 2 * DATA_W;

  logic [PTR_W-1:0]  sp, spUp;
  logic [DATA_W-1:0] byte0, byte1, loByte;
  logic [PC_W-1:0]   pcMinus;
  logic [DATA_W-1:0] rspDataQ;
  logic [PC_W-1:0]   rspPcQ;
  logic              rspValidQ;

  assign spUp      = sp + 1'b1;
  assign pcMinus   = cmdPc - 1'b1;
  assign memWrEn   = stb.wrByte0 | stb.wrByte1;
  assign memRdEn   = stb.rdIssue;
  assign memWrData = stb.wrByte1 ? byte1 : byte0;
  assign memAddr   = {PAGE_ID, (stb.rdIssue ? spUp : sp)};
  assign rspValid  = rspValidQ;
  assign rspData   = rspDataQ;
  assign rspPc     = rspPcQ;
  assign stackPtr  = sp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp        <= SP_INIT;
      byte0     <= '0;
      byte1     <= '0;
      loByte    <= '0;
      rspDataQ  <= '0;
      rspPcQ    <= '0;
      rspValidQ <= 1'b0;
    end else begin
      if (stb.latch) begin
        if (stb.latchCall)        byte0 <= pcMinus[PC_W-1:DATA_W];
        else if (stb.latchStatus) byte0 <= cmdData | STATUS_FORCE;
        else                      byte0 <= cmdData;
        byte1 <= pcMinus[DATA_W-1:0];
      end
      if (stb.loadPtr)                     sp <= cmdData;
      else if (memWrEn)                    sp <= sp - 1'b1;
      else if (stb.rdIssue && !stb.rdPeek) sp <= spUp;
      if (stb.capLo) loByte <= memRdData;
      rspValidQ <= stb.finish;
      if (stb.finish) begin
        rspDataQ <= memRdData;
        if (stb.finishRet) rspPcQ <= {memRdData, loByte} + 1'b1;
      end
    end
  end

  AST_PUSH_THEN_DEC: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> sp == PTR_W'($past(memAddr[PTR_W-1:0]) - 1'b1)); // R2

  AST_POP_INC_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && !stb.rdPeek |=> sp == $past(memAddr[PTR_W-1:0])); // R3

  AST_PEEK_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && stb.rdPeek |=> $stable(sp)); // R4

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWrEn, memRdEn, stb.loadPtr})); // R10

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R3

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn || memRdEn |-> memAddr[PAGE_W+DATA_W-1:DATA_W] == PAGE_ID); // R1

endmodule

// File: rtl/hwstack_top.sv
module hwstack_top
  import hwstack_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter int                PAGE_W       = 8,
  parameter logic [PAGE_W-1:0] PAGE_ID      = 8'h01,
  parameter logic [DATA_W-1:0] SP_INIT      = 8'hFF,
  parameter logic [DATA_W-1:0] STATUS_FORCE = 8'h30
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  output logic                     cmdReady,
  input  logic [2:0]               cmdOp,
  input  logic [DATA_W-1:0]        cmdData,
  input  logic [2*DATA_W-1:0]      cmdPc,
  output logic [PAGE_W+DATA_W-1:0] memAddr,
  output logic                     memWrEn,
  output logic [DATA_W-1:0]        memWrData,
  output logic                     memRdEn,
  input  logic [DATA_W-1:0]        memRdData,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspData,
  output logic [2*DATA_W-1:0]      rspPc,
  output logic [DATA_W-1:0]        stackPtr
);

  stackStrobe_t stb;

  hwstack_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdReady (cmdReady),
    .stb      (stb)
  );

  hwstack_dp #(
    .DATA_W       (DATA_W),
    .PAGE_W       (PAGE_W),
    .PAGE_ID      (PAGE_ID),
    .SP_INIT      (SP_INIT),
    .STATUS_FORCE (STATUS_FORCE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmdData   (cmdData),
    .cmdPc     (cmdPc),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .memRdEn   (memRdEn),
    .memRdData (memRdData),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .rspPc     (rspPc),
    .stackPtr  (stackPtr)
  );

endmodule

// File: tb/sim_hwstack_top.sv
module sim_hwstack_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = 3'd7;
  logic [7:0]  cmdData = 8'h00;
  logic [15:0] cmdPc = 16'h0000;
  logic [15:0] memAddr;
  logic        memWrEn, memRdEn, rspValid;
  logic [7:0]  memWrData, memRdData, rspData, stackPtr;
  logic [15:0] rspPc;

  always #5 clk = ~clk;

  hwstack_top u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdData(cmdData), .cmdPc(cmdPc), .memAddr(memAddr),
    .memWrEn(memWrEn), .memWrData(memWrData), .memRdEn(memRdEn),
    .memRdData(memRdData), .rspValid(rspValid), .rspData(rspData),
    .rspPc(rspPc), .stackPtr(stackPtr)
  );

  // memory model: synchronous read, one cycle latency
  logic [7:0] mem [0:511];
  logic [7:0] refMem [0:511];
  always_ff @(posedge clk) begin
    if (memWrEn) mem[memAddr[8:0]] <= memWrData;
    if (memRdEn) memRdData <= mem[memAddr[8:0]];
  end

  int nChecks = 0;
  int nFail = 0;
  int wrSeen = 0;
  bit done = 1'b0;
  logic [7:0] spM = 8'hFF;

  logic [15:0] wAddrQ[$];
  logic [7:0]  wDataQ[$];
  string       wTagQ[$];
  logic [7:0]  rDataQ[$];
  logic [15:0] rPcQ[$];
  bit          rPcChkQ[$];
  string       rTagQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: compare writes and responses against the scoreboard
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      wrSeen++;
      if (wAddrQ.size() == 0) check(1'b0, "R10", "unexpected write", {16'h0, memAddr}, 32'h0);
      else begin
        logic [15:0] ea;
        logic [7:0]  ed;
        string       t;
        ea = wAddrQ.pop_front();
        ed = wDataQ.pop_front();
        t  = wTagQ.pop_front();
        check(memAddr == ea, t, "write address", {16'h0, memAddr}, {16'h0, ea});
        check(memWrData == ed, t, "write data", {24'h0, memWrData}, {24'h0, ed});
      end
    end
    if (rstN && rspValid) begin
      if (rDataQ.size() == 0) check(1'b0, "R3", "unexpected response", {24'h0, rspData}, 32'h0);
      else begin
        logic [7:0]  ed;
        logic [15:0] ep;
        bit          pc;
        string       t;
        ed = rDataQ.pop_front();
        ep = rPcQ.pop_front();
        pc = rPcChkQ.pop_front();
        t  = rTagQ.pop_front();
        check(rspData == ed, t, "response data", {24'h0, rspData}, {24'h0, ed});
        if (pc) check(rspPc == ep, t, "response pc", {16'h0, rspPc}, {16'h0, ep});
      end
    end
  end

  task automatic expWrite(input logic [7:0] d, input string t);
    wAddrQ.push_back({8'h01, spM});
    wDataQ.push_back(d);
    wTagQ.push_back(t);
    refMem[{1'b1, spM}] = d;
    spM = spM - 8'd1;
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d,
                       input logic [15:0] pc, input string t);
    logic [15:0] pm;
    logic [7:0]  lo, hi;
    case (op)
      3'd0: expWrite(d, t);
      3'd5: expWrite(d | 8'h30, t);
      3'd3: begin
        pm = pc - 16'd1;
        expWrite(pm[15:8], t);
        expWrite(pm[7:0], t);
      end
      3'd1: begin
        spM = spM + 8'd1;
        rDataQ.push_back(refMem[{1'b1, spM}]); rPcQ.push_back(16'h0);
        rPcChkQ.push_back(1'b0); rTagQ.push_back(t);
      end
      3'd2: begin
        rDataQ.push_back(refMem[{1'b1, spM + 8'd1}]); rPcQ.push_back(16'h0);
        rPcChkQ.push_back(1'b0); rTagQ.push_back(t);
      end
      3'd4: begin
        spM = spM + 8'd1; lo = refMem[{1'b1, spM}];
        spM = spM + 8'd1; hi = refMem[{1'b1, spM}];
        rDataQ.push_back(hi); rPcQ.push_back({hi, lo} + 16'd1);
        rPcChkQ.push_back(1'b1); rTagQ.push_back(t);
      end
      3'd6: spM = d;
      default: ;
    endcase
    @(negedge clk);
    while (!cmdReady) @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = d; cmdPc = pc;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd7;
    if (op != 3'd6 && op != 3'd7)
      check(cmdReady == 1'b0, "R10", "ready low while busy", {31'h0, cmdReady}, 32'h0);
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    check(stackPtr == spM, t, "pointer", {24'h0, stackPtr}, {24'h0, spM});
  endtask

  initial begin
    int wrBefore;
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'h00;
      refMem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(stackPtr == 8'hFF, "R9", "reset pointer", {24'h0, stackPtr}, 32'hFF);
    check(cmdReady == 1'b1, "R10", "ready after reset", {31'h0, cmdReady}, 32'h1);
    check(rspValid == 1'b0, "R3", "no response after reset", {31'h0, rspValid}, 32'h0);

    issue(3'd0, 8'h42, 16'h0, "R2 R1");
    issue(3'd0, 8'hA0, 16'h0, "R2 R1");
    check(stackPtr == 8'hFD, "R2", "two pushes", {24'h0, stackPtr}, 32'hFD);
    issue(3'd2, 8'h00, 16'h0, "R4");
    issue(3'd1, 8'h00, 16'h0, "R3");
    issue(3'd1, 8'h00, 16'h0, "R3");
    issue(3'd5, 8'h81, 16'h0, "R7");
    issue(3'd5, 8'h00, 16'h0, "R7");
    issue(3'd1, 8'h00, 16'h0, "R7 R3");
    issue(3'd3, 8'h00, 16'h1234, "R5");
    issue(3'd4, 8'h00, 16'h0, "R6");
    issue(3'd3, 8'h00, 16'h1200, "R5");
    issue(3'd2, 8'h00, 16'h0, "R4");
    issue(3'd4, 8'h00, 16'h0, "R6");
    issue(3'd6, 8'h00, 16'h0, "R9");
    issue(3'd0, 8'h5A, 16'h0, "R8");
    check(stackPtr == 8'hFF, "R8", "push wrap", {24'h0, stackPtr}, 32'hFF);
    issue(3'd1, 8'h00, 16'h0, "R8");
    check(stackPtr == 8'h00, "R8", "pop wrap", {24'h0, stackPtr}, 32'h00);
    issue(3'd6, 8'h80, 16'h0, "R9");
    issue(3'd3, 8'h00, 16'h0000, "R5 R8");
    issue(3'd4, 8'h00, 16'h0, "R6 R8");
    wrBefore = wrSeen;
    issue(3'd7, 8'h33, 16'h0, "R10");
    check(wrSeen == wrBefore, "R10", "no-op writes", wrSeen, wrBefore);
    repeat (3) @(negedge clk);
    check(wAddrQ.size() == 0, "R2", "writes outstanding", wAddrQ.size(), 0);
    check(rDataQ.size() == 0, "R3", "responses outstanding", rDataQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog R10 actual=hung expected=idle");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule